// File: doc/BRIEF.md
# Code Prefetch Queue with Bus-Cycle Sequencer

This block is the fetch side of a processor with an 8-bit external bus. A bus sequencer runs read cycles, each of which fetches one code byte into a small FIFO. The execution side takes bytes from the head of that FIFO, marking each request as either the opening byte of an instruction or a later byte of it. On every clock the block reports what the queue did on a two-bit status output. A redirect request, which carries a new fetch address, empties the queue at once. It lets any bus cycle already in progress finish, but throws that cycle's byte away. After a fixed number of idle clocks, fetching restarts from the new address.

The sequencer has seven named states, shown on `bus_state` with this encoding: IDLE=0, T1=1, T2=2, T3=3, TW (wait)=4, T4=5, FLUSH=6. Its transitions are as follows:
- IDLE goes to FLUSH on redirect. Otherwise it goes to T1 when the queue will have a free slot after this clock, and stays in IDLE if not.
- T1 always goes to T2, and T2 always goes to T3.
- T3 and TW go to T4 when `ready` is high. When `ready` is low they go to TW.
- T4 goes to FLUSH on a redirect in this clock or on a pending one. Otherwise it goes to T1 when there is room, and to IDLE when there is not.
- FLUSH reloads its idle counter on a redirect. It goes to T1 when the counter is spent, and otherwise stays in FLUSH.

Top module: `pfq_fetch_unit`

## Requirements
- R1: Every bus cycle runs T1, T2, T3, any TW states, then T4, one state per clock, with `bus_state` encoded 0=IDLE, 1=T1, 2=T2, 3=T3, 4=TW, 5=T4, 6=FLUSH. Reset leaves one IDLE clock before the first T1.
- R2: When `ready` is low in a T3 or TW clock, the next clock is TW. T4 comes in the clock after the first T3 or TW clock that sees `ready` high.
- R3: `addr` stays constant from T1 to T4 of a cycle. The byte on `rdata` during T4 is written into the queue. Each new prefetch cycle uses the address one above the previous one, and bytes leave the queue in fetch order.
- R4: The queue holds at most 4 bytes. A new T1 follows T4 or IDLE directly only when the queue will have a free slot after that clock. After reset with no takes, exactly four cycles run and the sequencer then stays in IDLE.
- R5: A take with `take_first`=1 on a non-empty queue returns the oldest byte on `take_byte`, raises `take_valid`, and shows `qstat`=01 in that clock.
- R6: A take with `take_first`=0 on a non-empty queue returns the oldest byte and shows `qstat`=11 in that clock.
- R7: A take on an empty queue is not accepted. `take_valid` stays 0 and `qstat` is 00. The held request is first accepted in the clock right after the T4 that wrote a byte.
- R8: In a clock where `redirect` is high, `qstat` is 10, any take is refused, and all queued bytes are discarded.
- R9: A redirect during T1, T2, T3, TW or T4 lets that cycle reach T4, but its byte is dropped. No new T1 starts until the refill.
- R10: After a redirect, FLUSH lasts `FLUSH_IDLE` (3) clocks, counted from the end of any cycle in progress. T1 then starts at `redirect_addr`.
- R11: During and right after reset, `bus_state` is IDLE, `addr` is `RESET_ADDR` (0xFFFF0) and `qstat` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_req | input | 1 | Execution side requests a byte |
| take_first | input | 1 | 1: opening byte of an instruction, 0: later byte |
| redirect | input | 1 | Flush the queue and restart fetching |
| redirect_addr | input | AW (20) | New fetch address for redirect |
| ready | input | 1 | Memory ready; low adds wait states |
| rdata | input | 8 | Read data bus |
| addr | output | AW (20) | Address of the current bus cycle |
| bus_state | output | 3 | Sequencer state (see R1) |
| qstat | output | 2 | Queue status this clock: 00 none, 01 first, 10 flush, 11 subsequent |
| take_valid | output | 1 | Take accepted this clock |
| take_byte | output | 8 | Byte at the queue head |

## Verification
A wrong occupancy count shows within a single cycle as a T1 that should not start or a missing one: extra cycles past four after reset, or a stall after a take from a full queue. Lost pointer or discard state shows as a wrong `take_byte` on the first take after a refill, because the bench's memory returns a byte computed from the address. Flush-timing faults show as a T1 one or more clocks early or late against the cycle count worked out from the phase in which the redirect came. Wait-state faults show as a wrong number of TW clocks for each setting of the wait budget.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [2:0] {
        BS_IDLE  = 3'd0,
        BS_T1    = 3'd1,
        BS_T2    = 3'd2,
        BS_T3    = 3'd3,
        BS_TW    = 3'd4,
        BS_T4    = 3'd5,
        BS_FLUSH = 3'd6
    } bus_st_e;

    typedef enum logic [1:0] {
        QS_NONE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_EMPTY = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

endpackage

// File: rtl/pfq_queue.sv
module pfq_queue #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         wr_en,
    input  logic [DW-1:0]                wr_data,
    input  logic                         rd_en,
    output logic [DW-1:0]                rd_data,
    output logic                         empty,
    output logic                         room_next,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count_n;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        if (clear) begin
            count_n = '0;
        end else begin
            count_n = count + CW'(wr_en) - CW'(rd_en);
        end
        room_next = (count_n < CW'(DEPTH));
        empty     = (count == '0);
        rd_data   = store[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_n;
            if (clear) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (wr_en) wr_ptr <= bump(wr_ptr);
                if (rd_en) rd_ptr <= bump(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_ptr] <= wr_data;
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (count < CW'(DEPTH)));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (count != '0));

    // R8
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

endmodule

// File: rtl/pfq_seq.sv
module pfq_seq
    import pfq_pkg::*;
#(
    parameter int            AW         = 20,
    parameter int            FLUSH_IDLE = 3,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redirect,
    input  logic [AW-1:0] redirect_addr,
    input  logic          ready,
    input  logic          room_next,
    output logic [2:0]    bus_state,
    output logic [AW-1:0] bus_addr,
    output logic          cap_en
);
    localparam int FCW = (FLUSH_IDLE > 1) ? $clog2(FLUSH_IDLE) : 1;
    localparam logic [FCW-1:0] FLOAD = FCW'(FLUSH_IDLE - 1);

    bus_st_e        state, state_n;
    logic           pend;
    logic           busy;
    logic [AW-1:0]  next_addr;
    logic [FCW-1:0] fcnt;

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            BS_IDLE: begin
                if (redirect)       state_n = BS_FLUSH;
                else if (room_next) state_n = BS_T1;
                else                state_n = BS_IDLE;
            end
            BS_T1: state_n = BS_T2;
            BS_T2: state_n = BS_T3;
            BS_T3: state_n = ready ? BS_T4 : BS_TW;
            BS_TW: state_n = ready ? BS_T4 : BS_TW;
            BS_T4: begin
                if (redirect || pend) state_n = BS_FLUSH;
                else if (room_next)   state_n = BS_T1;
                else                  state_n = BS_IDLE;
            end
            BS_FLUSH: begin
                if (redirect)            state_n = BS_FLUSH;
                else if (fcnt == '0)     state_n = BS_T1;
                else                     state_n = BS_FLUSH;
            end
            default: state_n = BS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_state = state;
        busy      = (state == BS_T1) || (state == BS_T2) ||
                    (state == BS_T3) || (state == BS_TW);
        cap_en    = (state == BS_T4) && !pend && !redirect;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= BS_IDLE;
        else        state <= state_n;
    end

    // address, pending flag and flush counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            fcnt      <= '0;
            next_addr <= RESET_ADDR;
            bus_addr  <= RESET_ADDR;
        end else begin
            if (state == BS_T4)        pend <= 1'b0;
            else if (redirect && busy) pend <= 1'b1;

            if (state_n == BS_FLUSH && (state != BS_FLUSH || redirect))
                fcnt <= FLOAD;
            else if (state == BS_FLUSH && fcnt != '0)
                fcnt <= fcnt - 1'b1;

            if (redirect) begin
                next_addr <= redirect_addr;
            end else if (state_n == BS_T1) begin
                bus_addr  <= next_addr;
                next_addr <= next_addr + 1'b1;
            end
        end
    end

    // R1
    t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BS_T1) |=> (state == BS_T2));

    // R1
    t3_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BS_T3 && ready) |=> (state == BS_T4));

    // R2
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == BS_T3 || state == BS_TW) && !ready) |=> (state == BS_TW));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BS_T2 || state == BS_T3 || state == BS_TW || state == BS_T4)
            |-> $stable(bus_addr));

    // R9
    pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> (state != BS_T1));

    // R10
    flush_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BS_T1 && $past(state) == BS_FLUSH) |-> (bus_addr == $past(next_addr)));

endmodule

// File: rtl/pfq_fetch_unit.sv
module pfq_fetch_unit
    import pfq_pkg::*;
#(
    parameter int            AW         = 20,
    parameter int            DEPTH      = 4,
    parameter int            FLUSH_IDLE = 3,
    parameter logic [AW-1:0] RESET_ADDR = 20'hFFFF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_req,
    input  logic          take_first,
    input  logic          redirect,
    input  logic [AW-1:0] redirect_addr,
    input  logic          ready,
    input  logic [7:0]    rdata,
    output logic [AW-1:0] addr,
    output logic [2:0]    bus_state,
    output logic [1:0]    qstat,
    output logic          take_valid,
    output logic [7:0]    take_byte
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          q_empty;
    logic          room_next;
    logic          cap_en;
    logic          take_ok;
    logic [CW-1:0] q_count;
    logic [7:0]    head;

    assign take_ok = take_req && !redirect && !q_empty;

    pfq_queue #(
        .DEPTH (DEPTH),
        .DW    (8)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (redirect),
        .wr_en     (cap_en),
        .wr_data   (rdata),
        .rd_en     (take_ok),
        .rd_data   (head),
        .empty     (q_empty),
        .room_next (room_next),
        .count     (q_count)
    );

    pfq_seq #(
        .AW         (AW),
        .FLUSH_IDLE (FLUSH_IDLE),
        .RESET_ADDR (RESET_ADDR)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .redirect      (redirect),
        .redirect_addr (redirect_addr),
        .ready         (ready),
        .room_next     (room_next),
        .bus_state     (bus_state),
        .bus_addr      (addr),
        .cap_en        (cap_en)
    );

    always_comb begin
        take_valid = take_ok;
        take_byte  = head;
        if (redirect)     qstat = QS_EMPTY;
        else if (take_ok) qstat = take_first ? QS_FIRST : QS_NEXT;
        else              qstat = QS_NONE;
    end

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (q_count == '0 && qstat != QS_FIRST && qstat != QS_NEXT));

    // R7
    take_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> (q_count != '0));

    // R4
    full_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CW'(DEPTH) && !take_valid && !redirect && bus_state == BS_IDLE)
            |=> (bus_state == BS_IDLE));

endmodule

// File: tb/pfq_fetch_unit_bench.sv
module pfq_fetch_unit_bench;
    localparam int            AW  = 20;
    localparam int            NFL = 3;
    localparam logic [AW-1:0] RST = 20'hFFFF0;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          take_req, take_first, redirect;
    logic [AW-1:0] redirect_addr;
    logic          ready;
    logic [7:0]    rdata;
    wire  [AW-1:0] addr;
    wire  [2:0]    bus_state;
    wire  [1:0]    qstat;
    wire           take_valid;
    wire  [7:0]    take_byte;

    int total = 0;
    int bad   = 0;
    int wait_set  = 0;
    int wait_used = 0;
    bit done = 1'b0;

    pfq_fetch_unit u_pfq_fetch_unit (
        .clk(clk), .rst_n(rst_n), .take_req(take_req), .take_first(take_first),
        .redirect(redirect), .redirect_addr(redirect_addr), .ready(ready),
        .rdata(rdata), .addr(addr), .bus_state(bus_state), .qstat(qstat),
        .take_valid(take_valid), .take_byte(take_byte)
    );

    function automatic logic [7:0] mem(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h3C ^ {4'h0, a[15:12]};
    endfunction

    function automatic int ph_enc(input int p);
        case (p)
            0: return 1;
            1: return 2;
            2: return 3;
            default: return 5;
        endcase
    endfunction

    assign rdata = mem(addr);
    assign ready = !((bus_state == 3'd3 || bus_state == 3'd4) && wait_used < wait_set);

    always @(posedge clk) begin
        if (bus_state == 3'd1) wait_used <= 0;
        else if (!ready)       wait_used <= wait_used + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nxt;
        @(posedge clk);
        #1;
    endtask

    task automatic wait_idle;
        for (int g = 0; g < 100; g++) begin
            if (bus_state == 3'd0) break;
            nxt;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] na;
        int k;
        int exp_st;
        int lim;
        rst_n = 1'b0; take_req = 1'b0; take_first = 1'b0;
        redirect = 1'b0; redirect_addr = '0;
        repeat (3) nxt;
        #1;
        // R11 reset state
        chk(bus_state == 3'd0, "R11 state", bus_state, 0);
        chk(addr == RST, "R11 addr", addr, RST);
        chk(qstat == 2'b00, "R11 qstat", qstat, 0);
        chk(take_valid == 1'b0, "R11 take_valid", take_valid, 0);
        nxt;
        rst_n = 1'b1;

        // R1 / R3 / R4: fill after reset
        for (int i = 0; i < 20; i++) begin
            #1;
            if (i == 0 || i >= 17) begin
                chk(bus_state == 3'd0, "R4 idle", bus_state, 0);
            end else begin
                chk(bus_state == 3'(ph_enc((i - 1) % 4)), "R1 order", bus_state, ph_enc((i - 1) % 4));
                chk(addr == RST + AW'((i - 1) / 4), "R3 addr", addr, RST + AW'((i - 1) / 4));
            end
            nxt;
        end

        // R5 / R6 / R4 takes from a full queue
        take_req = 1'b1; take_first = 1'b1;
        #1;
        chk(take_valid == 1'b1, "R5 valid", take_valid, 1);
        chk(qstat == 2'b01, "R5 qstat", qstat, 1);
        chk(take_byte == mem(RST), "R5 byte", take_byte, mem(RST));
        nxt;
        take_first = 1'b0;
        #1;
        chk(qstat == 2'b11, "R6 qstat", qstat, 3);
        chk(take_byte == mem(RST + 1), "R6 byte", take_byte, mem(RST + 1));
        chk(bus_state == 3'd1, "R4 restart", bus_state, 1);
        chk(addr == RST + 4, "R4 addr", addr, RST + 4);
        nxt;

        // R3 / R7 drain in order with stalls
        k = 2;
        for (int c = 0; c < 80 && k < 8; c++) begin
            #1;
            if (take_valid) begin
                chk(take_byte == mem(RST + AW'(k)), "R3 order", take_byte, mem(RST + AW'(k)));
                k++;
            end else begin
                chk(qstat == 2'b00, "R7 stall qstat", qstat, 0);
            end
            nxt;
        end
        chk(k == 8, "R3 drained", k, 8);
        take_req = 1'b0;

        // R2 / R7 / R8 / R10 wait-state sweep after redirect from idle
        for (int w = 0; w < 4; w++) begin
            wait_set = w;
            wait_idle;
            na = 20'h01000 + AW'(w * 16);
            redirect = 1'b1; redirect_addr = na; take_req = 1'b1; take_first = 1'b1;
            #1;
            chk(qstat == 2'b10, "R8 qstat", qstat, 2);
            chk(take_valid == 1'b0, "R8 take refused", take_valid, 0);
            nxt;
            redirect = 1'b0;
            for (int j = 0; j < NFL; j++) begin
                #1;
                chk(bus_state == 3'd6, "R10 flush idle", bus_state, 6);
                chk(take_valid == 1'b0 && qstat == 2'b00, "R7 empty stall", qstat, 0);
                nxt;
            end
            #1;
            chk(bus_state == 3'd1, "R10 restart", bus_state, 1);
            chk(addr == na, "R10 addr", addr, na);
            nxt;
            for (int j = 0; j < 3 + w; j++) begin
                if (j == 0)      exp_st = 2;
                else if (j == 1) exp_st = 3;
                else if (j < 2 + w) exp_st = 4;
                else             exp_st = 5;
                #1;
                chk(bus_state == 3'(exp_st), "R2 wait sequence", bus_state, exp_st);
                chk(take_valid == 1'b0, "R7 no early take", take_valid, 0);
                nxt;
            end
            #1;
            chk(take_valid == 1'b1 && qstat == 2'b01, "R7 accept after T4", qstat, 1);
            chk(take_byte == mem(na), "R8 refill byte", take_byte, mem(na));
            nxt;
            take_req = 1'b0;
        end

        // R9 / R10 redirect in each phase of an active cycle
        wait_set = 0;
        for (int p = 0; p < 4; p++) begin
            wait_idle;
            take_req = 1'b1; take_first = 1'b1;
            nxt;
            take_req = 1'b0;
            repeat (p) nxt;
            na = 20'h02000 + AW'(p * 16);
            redirect = 1'b1; redirect_addr = na;
            #1;
            chk(qstat == 2'b10, "R8 qstat busy", qstat, 2);
            chk(bus_state == 3'(ph_enc(p)), "R9 phase", bus_state, ph_enc(p));
            nxt;
            redirect = 1'b0;
            lim = (3 - p) + NFL + 1;
            for (int j = 1; j <= lim; j++) begin
                if (j <= 3 - p)      exp_st = ph_enc(p + j);
                else if (j < lim)    exp_st = 6;
                else                 exp_st = 1;
                chk(bus_state == 3'(exp_st), "R9 finish then flush", bus_state, exp_st);
                if (j == lim) chk(addr == na, "R10 new addr", addr, na);
                nxt;
            end
            take_req = 1'b1; take_first = 1'b1;
            k = 0;
            for (int c = 0; c < 20; c++) begin
                #1;
                if (take_valid) begin
                    k = 1;
                    chk(take_byte == mem(na), "R9 stale dropped", take_byte, mem(na));
                    nxt;
                    break;
                end
                nxt;
            end
            chk(k == 1, "R9 refill taken", k, 1);
            take_req = 1'b0;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule